// File: doc/BRIEF.md
# Dual-Path Set/Clear Output Register

This block holds a 16-bit pattern that drives 16 output pins. Software reaches it through a plain synchronous register port. The port has an address, a write strobe, a read strobe, 32-bit write data and 32-bit read data. A transfer completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure: a strobe that is high at a rising edge is always taken.

There are two ways to change the pattern. A direct register loads all 16 bits at once and can also be read. A write-only set/clear register changes chosen bits without a read-modify-write. Both paths act on the same stored pattern, and the direct register always reads back the true current pattern.

A third address is a key-reset location. Any write to it returns the pattern to its default of all zeros.

Top module: `outreg_dual_path`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_pins` is 0x0000 and a read of any offset returns 0.
- R2: A write to offset 0x08 loads `wdata[15:0]` into the pattern at that clock edge. `wdata[31:16]` is ignored.
- R3: When `rd_en` is high with `addr` = 0x08, `rdata` returns {16'h0000, current pattern} in the same cycle. When `rd_en` is low, `rdata` is 0.
- R4: On a write to offset 0x0C, a 1 in `wdata` bit n (n = 0..15) drives output n to 1, and a 1 in bit n+16 drives output n to 0.
- R5: If a single write to 0x0C has both bit n and bit n+16 at 1, output n becomes 1.
- R6: On a write to 0x0C, every output whose set bit and clear bit are both 0 keeps its value. A write of all zeros leaves the pattern unchanged.
- R7: The pattern follows whichever of 0x08 or 0x0C was written last. A read of 0x08 shows changes made through 0x0C.
- R8: A write of any data to offset 0x60 clears all 16 outputs at that edge.
- R9: A read of offset 0x0C, 0x60 or any unmapped offset returns 0.
- R10: A write to any offset other than 0x08, 0x0C or 0x60 leaves the pattern unchanged.
- R11: A read of 0x08 in the same cycle as a write returns the pattern from before that write. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| rd_en | input | 1 | Read strobe, combinational return |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when no mapped read is made |
| out_pins | output | 16 | Current output pattern |

## Verification
A read and a write can fall in the same cycle. The bench drives both strobes together with `addr` at 0x08. It expects the returned word to be the pattern from before the edge and the pin value after the edge to be the new pattern. A second kind of overlap occurs inside one set/clear write, where the set and clear bits of the same output are both raised. The bench judges it by requiring those outputs to be 1 and every untouched output to keep its value. A behavioural reference model checks both cases every clock, on directed and random traffic.

// File: rtl/outreg_pkg.sv
package outreg_pkg;
  // Kind of write taken on the current edge
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_DIRECT = 2'd1,
    WR_SETCLR = 2'd2,
    WR_KEYRST = 2'd3
  } wr_kind_t;

  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_OUT_W    = 16;
  localparam logic [7:0]  DEF_OFS_DIR  = 8'h08;
  localparam logic [7:0]  DEF_OFS_SC   = 8'h0C;
  localparam logic [7:0]  DEF_OFS_KEY  = 8'h60;
endpackage

// File: rtl/outreg_decode.sv
module outreg_decode
  import outreg_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(DEF_OFS_DIR),
  parameter logic [ADDR_W-1:0] OFS_SC  = ADDR_W'(DEF_OFS_SC),
  parameter logic [ADDR_W-1:0] OFS_KEY = ADDR_W'(DEF_OFS_KEY)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output wr_kind_t          wr_kind,
  output logic              rd_direct
);
  always_comb begin
    wr_kind = WR_NONE;
    if (wr_en) begin
      if (addr == OFS_DIR)      wr_kind = WR_DIRECT;
      else if (addr == OFS_SC)  wr_kind = WR_SETCLR;
      else if (addr == OFS_KEY) wr_kind = WR_KEYRST;
    end
  end

  // Only the direct register is readable
  assign rd_direct = rd_en && (addr == OFS_DIR);
endmodule

// File: rtl/outreg_bitcell.sv
module outreg_bitcell
  import outreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wr_kind_t wr_kind,
  input  logic     load_bit,
  input  logic     set_bit,
  input  logic     clr_bit,
  output logic     q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    unique case (wr_kind)
      WR_DIRECT: q_nxt = load_bit;
      WR_SETCLR: q_nxt = set_bit | (q & ~clr_bit);  // set wins
      WR_KEYRST: q_nxt = 1'b0;
      default:   q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/outreg_readmux.sv
module outreg_readmux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OUT_W  = 16
) (
  input  logic              rd_direct,
  input  logic [OUT_W-1:0]  pattern,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - OUT_W;

  always_comb begin
    rdata = '0;
    if (rd_direct) rdata = {{PAD_W{1'b0}}, pattern};
  end
endmodule

// File: rtl/outreg_dual_path.sv
module outreg_dual_path
  import outreg_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(DEF_OFS_DIR),
  parameter logic [ADDR_W-1:0] OFS_SC  = ADDR_W'(DEF_OFS_SC),
  parameter logic [ADDR_W-1:0] OFS_KEY = ADDR_W'(DEF_OFS_KEY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [OUT_W-1:0]  out_pins
);
  // Clear field sits directly above the set field
  localparam int unsigned CLR_LSB = OUT_W;

  wr_kind_t         wr_kind;
  logic             rd_direct;
  logic [OUT_W-1:0] pattern;

  outreg_decode #(
    .ADDR_W(ADDR_W), .OFS_DIR(OFS_DIR), .OFS_SC(OFS_SC), .OFS_KEY(OFS_KEY)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_kind(wr_kind), .rd_direct(rd_direct)
  );

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    outreg_bitcell u_cell (
      .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind),
      .load_bit(wdata[i]), .set_bit(wdata[i]), .clr_bit(wdata[CLR_LSB+i]),
      .q(pattern[i])
    );
  end

  outreg_readmux #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_rmux (
    .rd_direct(rd_direct), .pattern(pattern), .rdata(rdata)
  );

  assign out_pins = pattern;
endmodule

// File: rtl/outreg_checker.sv
module outreg_checker
  import outreg_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(DEF_OFS_DIR),
  parameter logic [ADDR_W-1:0] OFS_SC  = ADDR_W'(DEF_OFS_SC),
  parameter logic [ADDR_W-1:0] OFS_KEY = ADDR_W'(DEF_OFS_KEY)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [OUT_W-1:0]  out_pins
);
  logic hit_any;
  assign hit_any = (addr == OFS_DIR) || (addr == OFS_SC) || (addr == OFS_KEY);

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIR) |=> out_pins == $past(wdata[OUT_W-1:0]));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_SC) |=>
      out_pins == (($past(out_pins) & ~$past(wdata[2*OUT_W-1:OUT_W]))
                   | $past(wdata[OUT_W-1:0])));

  // R8
  key_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_KEY) |=> out_pins == '0);

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_any) |=> $stable(out_pins));

  // R9
  read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == OFS_DIR) |-> rdata == '0);

  // R3
  read_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_DIR) |-> rdata[OUT_W-1:0] == out_pins
                                   && rdata[DATA_W-1:OUT_W] == '0);
endmodule

bind outreg_dual_path outreg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_W(OUT_W),
  .OFS_DIR(OFS_DIR), .OFS_SC(OFS_SC), .OFS_KEY(OFS_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .out_pins(out_pins)
);

// File: tb/tb_outreg_dual_path.sv
module tb_outreg_dual_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [15:0] out_pins;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [15:0] model = 16'h0;   // reference pattern

  always #10 clk = ~clk;        // 50 MHz

  outreg_dual_path dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .out_pins(out_pins)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive on the falling edge, check before the rise, update model after it
  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #5;
    exp_rd = (r && a == 8'h08) ? {16'h0, model} : 32'h0;
    check({tag, " pins"}, {16'h0, out_pins}, {16'h0, model});
    check({tag, " rdata"}, rdata, exp_rd);
    @(posedge clk);
    if (w) begin
      case (a)
        8'h08: model = d[15:0];
        8'h0C: model = (model & ~d[31:16]) | d[15:0];
        8'h60: model = 16'h0;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] amap [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h60, 8'h7F};
    // R1: state under reset
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h08;
    #5;
    check("R1 pins in reset", {16'h0, out_pins}, 32'h0);
    check("R1 rdata in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1; rd_en = 1'b0;
    step(1'b0, 1'b1, 8'h08, 32'h0, "R1");
    // R2 / R3: direct load, upper bits ignored, readback
    step(1'b1, 1'b0, 8'h08, 32'hFFFF_A5C3, "R2");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R3");
    step(1'b0, 1'b0, 8'h08, 32'h0, "R3 idle");
    // R4: clear bits 0,1 and set 10,11
    step(1'b1, 1'b0, 8'h0C, 32'h0003_0C00, "R4");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R4 readback");
    // R5: both set and clear on bits 4..7
    step(1'b1, 1'b0, 8'h0C, 32'h00F0_00F0, "R5");
    step(1'b1, 1'b0, 8'h0C, 32'hFFFF_FFFF, "R5 all");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R5 readback");
    // R6: zero write changes nothing
    step(1'b1, 1'b0, 8'h0C, 32'h0, "R6");
    step(1'b1, 1'b0, 8'h0C, 32'h8000_0001, "R6 partial");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R6 readback");
    // R7: last writer wins
    step(1'b1, 1'b0, 8'h08, 32'h0000_1234, "R7");
    step(1'b1, 1'b0, 8'h0C, 32'h1200_0001, "R7");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R7 readback");
    // R9: non-readable offsets return zero
    step(1'b0, 1'b1, 8'h0C, 32'h0, "R9 setclr read");
    step(1'b0, 1'b1, 8'h60, 32'h0, "R9 key read");
    step(1'b0, 1'b1, 8'h04, 32'h0, "R9 unmapped read");
    // R10: unmapped writes ignored
    step(1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF, "R10");
    step(1'b1, 1'b0, 8'h64, 32'hFFFF_0000, "R10");
    step(1'b1, 1'b0, 8'h09, 32'h0000_0000, "R10");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R10 readback");
    // R11: read and write in the same cycle
    step(1'b1, 1'b1, 8'h08, 32'h0000_BEEF, "R11");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R11 after");
    // R8: key reset with arbitrary data
    step(1'b1, 1'b0, 8'h60, 32'hDEAD_BEEF, "R8");
    step(1'b0, 1'b1, 8'h08, 32'h0, "R8 readback");
    // R7: random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = amap[$urandom_range(6)];
      if (a == 8'h60 && $urandom_range(7) != 0) a = 8'h0C;
      step(1'($urandom_range(1)), 1'($urandom_range(1)), a, $urandom, "R7 random");
    end
    step(1'b0, 1'b0, 8'h00, 32'h0, "R7 final");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule